// File: doc/BRIEF.md
# Dual-Channel Timer Register File

This block is the software-facing register layer for a pair of timer channels. A simple single-cycle register bus reads and writes six word registers: for each channel a control/status word, a load word and a read-only count word. The decoded control fields go out to the channel datapaths. The block takes the channels' event pulses and count values back in. It owns the per-channel interrupt flags and folds them into one interrupt line.

A write that sets the shared enable-all bit turns on both channels in one cycle. Interrupt flags are sticky. Software clears them by writing a one to the flag position. Reads are combinational: the word for the addressed register appears on `rdata_o` in the same cycle as `sel_i`. Bit positions below are given as vector indices, with index 0 the least significant.

Top module: `tmr_regfile`

## Requirements
- R1: After reset every control field, both interrupt flags, the enable-all bit, both load registers and `irq_o` are 0.
- R2: Decode uses `addr_i[1:0]`==0, channel = `addr_i[4]`, slot = `addr_i[3:2]` (0 control/status, 1 load, 2 count). So the control/status words sit at 0x00 and 0x10, the load words at 0x04 and 0x14, and the count words at 0x08 and 0x18. Every other offset reads 0, and a write to it changes nothing.
- R3: Control/status word indices: 0 mode, 1 count-down, 2 generate enable, 3 capture enable, 4 auto-reload, 5 load, 6 interrupt enable, 7 timer enable, 9 PWM enable. Each index reads back what was last written to it.
- R4: Indices 31..11 of a control/status word always read 0, whatever was written to them.
- R5: Index 10 is enable-all. Writing 1 there through either control/status word sets enable-all and the timer enable (index 7) of both channels.
- R6: Writing 0 to enable-all clears only enable-all and leaves the other channel's timer enable unchanged. Enable-all reads the same in both control/status words.
- R7: Index 8 is the interrupt flag. A channel event pulse sets it one cycle later. Writing 1 to index 8 clears it, and writing 0 leaves it unchanged.
- R8: When an event and a write-1 clear reach the same flag in the same cycle, the flag ends set.
- R9: `irq_o` is the OR over channels of flag AND interrupt enable. The interrupt enable never changes the flag.
- R10: Load words hold the low CNT_W bits of the written data and read back zero-extended. Count words return `count_i` zero-extended, and writes to them are ignored.
- R11: `load_rd_o[c]` is high in exactly the cycles in which the bus reads channel c's load word.
- R12: The per-channel control outputs (`ch_mode_o`, `ch_down_o`, `ch_gen_o`, `ch_cap_o`, `ch_reload_o`, `ch_load_o`, `ch_en_o`, `ch_pwm_o`) equal the stored fields. `load_val_o` carries each stored load value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access this cycle |
| wr_i | input | 1 | 1 write, 0 read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| evt_i | input | N_CH | Per-channel event pulse |
| count_i | input | N_CH*CNT_W | Per-channel count value |
| load_val_o | output | N_CH*CNT_W | Per-channel load value |
| load_rd_o | output | N_CH | Load-word read strobe |
| ch_mode_o | output | N_CH | Mode field |
| ch_down_o | output | N_CH | Count direction field |
| ch_gen_o | output | N_CH | Generate enable field |
| ch_cap_o | output | N_CH | Capture enable field |
| ch_reload_o | output | N_CH | Auto-reload field |
| ch_load_o | output | N_CH | Load field |
| ch_en_o | output | N_CH | Timer enable |
| ch_pwm_o | output | N_CH | PWM enable field |
| irq_o | output | 1 | Combined interrupt |

## Verification
Assertions check the following on every cycle:
- an event always leaves the flag set, including when a clear arrives in the same cycle;
- a write of 0 never drops a flag;
- an enable-all write always turns on both timer enables;
- reserved and unmapped reads return zeros;
- the load read strobes stay one-hot;
- the interrupt line never rises without an enabled channel.

Only the bench scenarios show the following:
- each field lands at its documented index;
- clearing enable-all leaves the other channel untouched;
- load data is truncated and right-justified;
- writes to count words or unmapped offsets change no stored state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned B_MODE = 0;
  localparam int unsigned B_DOWN = 1;
  localparam int unsigned B_GEN  = 2;
  localparam int unsigned B_CAP  = 3;
  localparam int unsigned B_ARH  = 4;
  localparam int unsigned B_LOAD = 5;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_EN   = 7;
  localparam int unsigned B_FLAG = 8;
  localparam int unsigned B_PWM  = 9;
  localparam int unsigned B_ALL  = 10;
  localparam int unsigned CSR_W  = 11;

  localparam logic [1:0] SLOT_CSR  = 2'd0;
  localparam logic [1:0] SLOT_LOAD = 2'd1;
  localparam logic [1:0] SLOT_CNT  = 2'd2;

  typedef struct packed {
    logic pwm;
    logic en;
    logic ie;
    logic load;
    logic arh;
    logic cap;
    logic gen;
    logic down;
    logic mode;
  } ctl_t;

  function automatic logic [31:0] pack_csr(ctl_t c, logic flag, logic all);
    logic [31:0] w;
    w         = '0;
    w[B_MODE] = c.mode;
    w[B_DOWN] = c.down;
    w[B_GEN]  = c.gen;
    w[B_CAP]  = c.cap;
    w[B_ARH]  = c.arh;
    w[B_LOAD] = c.load;
    w[B_IE]   = c.ie;
    w[B_EN]   = c.en;
    w[B_FLAG] = flag;
    w[B_PWM]  = c.pwm;
    w[B_ALL]  = all;
    return w;
  endfunction
endpackage

// File: rtl/tmr_dec.sv
module tmr_dec #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CH-1:0]   hit_csr_o,
  output logic [N_CH-1:0]   hit_load_o,
  output logic [N_CH-1:0]   hit_cnt_o
);
  import tmr_pkg::*;
  localparam int unsigned CH_W = ADDR_W - 4;

  logic base_ok;
  assign base_ok = sel_i && (addr_i[1:0] == 2'b00);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic ch_hit;
    assign ch_hit        = base_ok && (addr_i[ADDR_W-1:4] == CH_W'(c));
    assign hit_csr_o[c]  = ch_hit && (addr_i[3:2] == SLOT_CSR);
    assign hit_load_o[c] = ch_hit && (addr_i[3:2] == SLOT_LOAD);
    assign hit_cnt_o[c]  = ch_hit && (addr_i[3:2] == SLOT_CNT);
  end
endmodule

// File: rtl/tmr_ch_csr.sv
module tmr_ch_csr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      csr_we_i,
  input  logic                      load_we_i,
  input  logic [tmr_pkg::CSR_W-1:0] csr_wdata_i,
  input  logic [CNT_W-1:0]          load_wdata_i,
  input  logic                      set_en_i,
  input  logic                      evt_i,
  output tmr_pkg::ctl_t             ctl_o,
  output logic                      flag_o,
  output logic [CNT_W-1:0]          load_val_o
);
  import tmr_pkg::*;

  ctl_t             ctl_q;
  logic             flag_q;
  logic [CNT_W-1:0] load_q;
  logic             clr;

  assign clr = csr_we_i && csr_wdata_i[B_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
      load_q <= '0;
    end else begin
      if (csr_we_i) begin
        ctl_q.mode <= csr_wdata_i[B_MODE];
        ctl_q.down <= csr_wdata_i[B_DOWN];
        ctl_q.gen  <= csr_wdata_i[B_GEN];
        ctl_q.cap  <= csr_wdata_i[B_CAP];
        ctl_q.arh  <= csr_wdata_i[B_ARH];
        ctl_q.load <= csr_wdata_i[B_LOAD];
        ctl_q.ie   <= csr_wdata_i[B_IE];
        ctl_q.en   <= csr_wdata_i[B_EN] | csr_wdata_i[B_ALL];
        ctl_q.pwm  <= csr_wdata_i[B_PWM];
      end else if (set_en_i) begin
        ctl_q.en <= 1'b1;
      end
      // set has priority over write-one-to-clear
      flag_q <= evt_i | (flag_q & ~clr);
      if (load_we_i) load_q <= load_wdata_i;
    end
  end

  assign ctl_o      = ctl_q;
  assign flag_o     = flag_q;
  assign load_val_o = load_q;

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o);
  assert_flag_w0_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr) |=> flag_o);
  assert_set_beats_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && clr) |=> flag_o);
  assert_enall_sets_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ctl_o.en);
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sel_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [N_CH-1:0]         evt_i,
  input  logic [N_CH*CNT_W-1:0]   count_i,
  output logic [N_CH*CNT_W-1:0]   load_val_o,
  output logic [N_CH-1:0]         load_rd_o,
  output logic [N_CH-1:0]         ch_mode_o,
  output logic [N_CH-1:0]         ch_down_o,
  output logic [N_CH-1:0]         ch_gen_o,
  output logic [N_CH-1:0]         ch_cap_o,
  output logic [N_CH-1:0]         ch_reload_o,
  output logic [N_CH-1:0]         ch_load_o,
  output logic [N_CH-1:0]         ch_en_o,
  output logic [N_CH-1:0]         ch_pwm_o,
  output logic                    irq_o
);
  import tmr_pkg::*;

  logic [N_CH-1:0] hit_csr, hit_load, hit_cnt;
  logic [N_CH-1:0] csr_we, load_we, flag, ie;
  logic            any_csr_we, set_all, all_q;
  ctl_t            ctl [N_CH];
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i;

  tmr_dec #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .sel_i      (sel_i),
    .addr_i     (addr_i),
    .hit_csr_o  (hit_csr),
    .hit_load_o (hit_load),
    .hit_cnt_o  (hit_cnt)
  );

  assign csr_we     = hit_csr & {N_CH{wr_i}};
  assign load_we    = hit_load & {N_CH{wr_i}};
  assign load_rd_o  = hit_load & {N_CH{~wr_i}};
  assign any_csr_we = |csr_we;
  assign set_all    = any_csr_we && wdata_i[B_ALL];

  // enable-all is shared by every control/status word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         all_q <= 1'b0;
    else if (any_csr_we) all_q <= wdata_i[B_ALL];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tmr_ch_csr #(.CNT_W(CNT_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .csr_we_i     (csr_we[c]),
      .load_we_i    (load_we[c]),
      .csr_wdata_i  (wdata_i[CSR_W-1:0]),
      .load_wdata_i (wdata_i[CNT_W-1:0]),
      .set_en_i     (set_all),
      .evt_i        (evt_i[c]),
      .ctl_o        (ctl[c]),
      .flag_o       (flag[c]),
      .load_val_o   (load_val_o[c*CNT_W +: CNT_W])
    );
    assign ie[c]          = ctl[c].ie;
    assign ch_mode_o[c]   = ctl[c].mode;
    assign ch_down_o[c]   = ctl[c].down;
    assign ch_gen_o[c]    = ctl[c].gen;
    assign ch_cap_o[c]    = ctl[c].cap;
    assign ch_reload_o[c] = ctl[c].arh;
    assign ch_load_o[c]   = ctl[c].load;
    assign ch_en_o[c]     = ctl[c].en;
    assign ch_pwm_o[c]    = ctl[c].pwm;
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (hit_csr[c])  rdata_o = rdata_o | pack_csr(ctl[c], flag[c], all_q);
      if (hit_load[c]) rdata_o = rdata_o | 32'(load_val_o[c*CNT_W +: CNT_W]);
      if (hit_cnt[c])  rdata_o = rdata_o | 32'(count_i[c*CNT_W +: CNT_W]);
    end
  end

  assign irq_o = |(flag & ie);

  assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && |hit_csr) |-> (rdata_o[31:CSR_W] == '0));
  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !(|{hit_csr, hit_load, hit_cnt})) |-> (rdata_o == '0));
  assert_rd_strobe_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_rd_o));
  assert_irq_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |ie);
  assert_enall_both_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_all |=> (ch_en_o == '1));
endmodule

// File: tb/tb_tmr_regfile.sv
module tb_tmr_regfile;
  localparam int N_CH = 2, CNT_W = 16, ADDR_W = 5;

  logic clk = 0, rst_ni = 0;
  logic sel = 0, wr = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N_CH-1:0] evt = '0;
  logic [N_CH*CNT_W-1:0] count = '0, load_val;
  logic [N_CH-1:0] load_rd, c_mode, c_down, c_gen, c_cap, c_rel, c_load, c_en, c_pwm;
  logic irq;

  int errs = 0, chks = 0;
  logic [31:0] m_csr [N_CH];
  logic [CNT_W-1:0] m_load [N_CH];
  logic m_all;
  logic [N_CH-1:0] m_flag;

  always #10 clk = ~clk;

  tmr_regfile #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .count_i(count),
    .load_val_o(load_val), .load_rd_o(load_rd), .ch_mode_o(c_mode),
    .ch_down_o(c_down), .ch_gen_o(c_gen), .ch_cap_o(c_cap),
    .ch_reload_o(c_rel), .ch_load_o(c_load), .ch_en_o(c_en),
    .ch_pwm_o(c_pwm), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_csr(int c);
    return m_csr[c] | (32'(m_all) << 10) | (32'(m_flag[c]) << 8);
  endfunction

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, output logic [31:0] d, output logic [N_CH-1:0] s);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata; s = load_rd;
    @(negedge clk); sel = 0;
  endtask

  task automatic model_csr_wr(int c, logic [31:0] d);
    m_csr[c] = d & 32'h0000_02FF;
    m_all = d[10];
    if (d[10]) for (int k = 0; k < N_CH; k++) m_csr[k][7] = 1'b1;
    if (d[8]) m_flag[c] = 1'b0;
  endtask

  task automatic chk_outs(int c, string req);
    logic [7:0] act, exp;
    act = {c_pwm[c], c_en[c], c_load[c], c_rel[c], c_cap[c], c_gen[c], c_down[c], c_mode[c]};
    exp = {m_csr[c][9], m_csr[c][7], m_csr[c][5], m_csr[c][4], m_csr[c][3],
           m_csr[c][2], m_csr[c][1], m_csr[c][0]};
    chk(req, 32'(act), 32'(exp));
    chk({req, " load_val"}, 32'(load_val[c*CNT_W +: CNT_W]), 32'(m_load[c]));
  endtask

  task automatic chk_all_regs(string req);
    logic [31:0] d; logic [N_CH-1:0] s;
    for (int c = 0; c < N_CH; c++) begin
      bus_rd(5'(c*16), d, s);     chk({req, " csr"}, d, exp_csr(c));
      bus_rd(5'(c*16 + 4), d, s); chk({req, " load"}, d, 32'(m_load[c]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; chks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    logic [31:0] d; logic [N_CH-1:0] s;
    for (int c = 0; c < N_CH; c++) begin m_csr[c] = '0; m_load[c] = '0; end
    m_all = 0; m_flag = '0;
    count = {16'h1234, 16'h5678};
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    for (int c = 0; c < N_CH; c++) chk_outs(c, "R1 outputs");
    chk_all_regs("R1");

    // R3 R4 R5 R12 single-bit sweep of both control/status words
    for (int c = 0; c < N_CH; c++)
      for (int b = 0; b < 32; b++) begin
        bus_wr(5'(c*16), 32'(1) << b);
        model_csr_wr(c, 32'(1) << b);
        bus_rd(5'(c*16), d, s);
        chk(b > 10 ? "R4 reserved" : (b == 10 ? "R5 enable-all" : "R3 field"), d, exp_csr(c));
        chk_outs(c, "R12 fields");
      end
    bus_rd(5'h00, d, s); chk("R5 ch0 en", 32'(d[7]), 32'(m_csr[0][7]));
    bus_rd(5'h10, d, s); chk("R5 ch1 en", 32'(d[7]), 32'(m_csr[1][7]));

    // R5 R6 enable-all set then clear
    bus_wr(5'h10, 0); model_csr_wr(1, 0);
    bus_wr(5'h00, 0); model_csr_wr(0, 0);
    bus_wr(5'h00, 32'h400); model_csr_wr(0, 32'h400);
    chk("R5 both enables", 32'(c_en), 32'h3);
    bus_rd(5'h00, d, s); chk("R6 mirror csr0", 32'(d[10]), 1);
    bus_rd(5'h10, d, s); chk("R6 mirror csr1", 32'(d[10]), 1);
    bus_wr(5'h00, 32'h080); model_csr_wr(0, 32'h080);
    bus_rd(5'h10, d, s); chk("R6 clear keeps ch1", d, 32'h080);
    bus_rd(5'h00, d, s); chk("R6 clear all only", d, 32'h080);

    // R7 R9 flag and interrupt
    bus_wr(5'h00, 32'h040); model_csr_wr(0, 32'h040);
    @(negedge clk); evt = 2'b01; @(negedge clk); evt = 0; m_flag[0] = 1;
    chk("R9 irq enabled", 32'(irq), 1);
    bus_wr(5'h00, 32'h000); model_csr_wr(0, 0);
    chk("R9 irq gated", 32'(irq), 0);
    bus_rd(5'h00, d, s); chk("R7 w0 keeps flag", d, 32'h100);
    bus_wr(5'h10, 32'h040); model_csr_wr(1, 32'h040);
    @(negedge clk); evt = 2'b10; @(negedge clk); evt = 0; m_flag[1] = 1;
    chk("R9 irq or ch1", 32'(irq), 1);
    bus_wr(5'h10, 32'h140); model_csr_wr(1, 32'h140);
    chk("R7 w1c irq", 32'(irq), 0);
    bus_rd(5'h10, d, s); chk("R7 w1c", d, 32'h040);
    // R8 event and clear same cycle
    @(negedge clk); sel = 1; wr = 1; addr = 5'h00; wdata = 32'h100; evt = 2'b01;
    @(negedge clk); sel = 0; wr = 0; wdata = 0; evt = 0;
    model_csr_wr(0, 32'h100); m_flag[0] = 1;
    bus_rd(5'h00, d, s); chk("R8 set wins", d, 32'h100);

    // R10 R11 load and count words
    bus_wr(5'h04, 32'hFFFF_ABCD); m_load[0] = 16'hABCD;
    bus_wr(5'h14, 32'h0001_2468); m_load[1] = 16'h2468;
    bus_rd(5'h04, d, s); chk("R10 load0", d, 32'hABCD); chk("R11 strobe0", 32'(s), 1);
    bus_rd(5'h14, d, s); chk("R10 load1", d, 32'h2468); chk("R11 strobe1", 32'(s), 2);
    bus_rd(5'h00, d, s); chk("R11 no strobe csr", 32'(s), 0);
    bus_wr(5'h04, 32'h5555); m_load[0] = 16'h5555;
    chk("R11 no strobe write", 32'(load_rd), 0);
    chk_outs(0, "R12 load0");
    bus_rd(5'h08, d, s); chk("R10 count0", d, 32'h5678);
    bus_rd(5'h18, d, s); chk("R10 count1", d, 32'h1234);
    bus_wr(5'h08, 32'hFFFF_FFFF);
    bus_rd(5'h08, d, s); chk("R10 count ro", d, 32'h5678);
    chk_all_regs("R10 count write ignored");

    // R2 every unmapped or misaligned offset
    for (int a = 0; a < 32; a++)
      if (a[1:0] != 0 || a[3:2] == 3) begin
        bus_wr(5'(a), 32'hFFFF_FFFF);
        bus_rd(5'(a), d, s); chk("R2 unmapped read", d, 0);
      end
    chk_all_regs("R2 unmapped write ignored");
    for (int c = 0; c < N_CH; c++) chk_outs(c, "R12 final");

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule